// File: doc/BRIEF.md
# SDRAM Single-Write Command Sequencer

This block sits on the controller side of a 16-bit SDRAM. It takes one write request (bank, row, column and one data word) and turns it into the full command sequence for a single-beat write. It opens the row, waits, issues the write with the data word, waits again, and then closes the row with an explicit single-bank precharge. Every wait between commands is filled with NOP cycles. The length of each wait comes from timing parameters given in clock cycles.

A lone write to a freshly opened row can finish long before the row has been open for the minimum active-to-precharge time. In that case the recovery wait after the write is lengthened so that the precharge still lands no earlier than that minimum allows. The requester sees a ready/valid handshake. Ready falls when a request is taken and returns only when both the precharge time and the row-cycle time would be met by the very next activate. Requests can therefore be issued back to back without the caller tracking any timing.

The data bus is presented as a data output and an output-enable. The pad tri-state driver is outside this block.

Top module: `sdram_write_seq`

## Requirements
- R1: While reset is asserted and after it is released, `req_ready` is 1, the command lines show NOP ({CS#,RAS#,CAS#,WE#} = 0111), CKE is 1, `sd_dq_oe` is 0 and DQM is all ones.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. The next cycle carries ACTIVE ({CS#,RAS#,CAS#,WE#} = 0011) with the request's row on the address bus and its bank on the bank lines.
- R3: WRITE ({CS#,RAS#,CAS#,WE#} = 0100) comes exactly T_RCD cycles after ACTIVE. It carries the request's bank and the column in the low address bits. Address bit 10 (auto precharge) and every other address bit above the column are 0.
- R4: `sd_dq_oe` is 1 and DQM is all zeros only in the WRITE cycle, with the request's data on `sd_dq_o`. In every other cycle `sd_dq_oe` is 0 and DQM is all ones.
- R5: PRECHARGE ({CS#,RAS#,CAS#,WE#} = 0010) comes max(T_WR, T_RAS − T_RCD) cycles after WRITE. It is thus at least T_WR after the write and at least T_RAS after ACTIVE. With the default parameters the recovery is stretched from 4 to 6 cycles.
- R6: PRECHARGE targets one bank only. Address bit 10 is 0 and the bank lines equal the bank that was opened.
- R7: `req_ready` returns to 1 in the cycle before the earliest legal next ACTIVE, which is max(PRECHARGE + T_RP, ACTIVE + T_RC). A request taken there puts its ACTIVE exactly on that cycle.
- R8: From ACTIVE until ready returns, `req_ready` is 0 and `req_valid` has no effect. No extra command is issued, and the data and addresses of the request in flight are unchanged.
- R9: Every cycle that carries none of ACTIVE, WRITE or PRECHARGE carries NOP, and CKE stays 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_data | input | DATA_W | Word to write |
| sd_cke | output | 1 | Clock enable, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ROW_W | Multiplexed address |
| sd_ba | output | BANK_W | Bank address |
| sd_dqm | output | DATA_W/8 | Byte masks, high outside the write |
| sd_dq_o | output | DATA_W | Write data to the pad driver |
| sd_dq_oe | output | 1 | Pad driver enable |

## Verification
The bench follows every request cycle by cycle, from acceptance until ready returns, and compares the command, ready, enable and mask lines against offsets it computes from the parameters. The default timings make the active-to-precharge limit the binding one. A design that used the plain write-recovery count would therefore precharge two cycles early, and one that ignored the row-cycle limit or raised ready late would misplace the next ACTIVE.

Each request is followed directly by the next, so any slack or early ready shows up as a shifted ACTIVE. Rows with bit 10 set, all-ones columns and all-ones banks expose an auto-precharge bit that leaks through, or a precharge that wrongly addresses all banks.

Junk requests are presented while the block is busy. A design that latched them would write the wrong word or issue a stray ACTIVE. A reset in the middle of a sequence must return the lines to idle and leave a clean next write.

// File: rtl/sdram_write_seq.sv
module sdram_write_seq #(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  parameter int DATA_W = 16,
  parameter int T_RCD  = 5,
  parameter int T_WR   = 4,
  parameter int T_RAS  = 11,
  parameter int T_RP   = 5,
  parameter int T_RC   = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [BANK_W-1:0]   req_bank,
  input  logic [ROW_W-1:0]    req_row,
  input  logic [COL_W-1:0]    req_col,
  input  logic [DATA_W-1:0]   req_data,
  output logic                sd_cke,
  output logic                sd_cs_n,
  output logic                sd_ras_n,
  output logic                sd_cas_n,
  output logic                sd_we_n,
  output logic [ROW_W-1:0]    sd_addr,
  output logic [BANK_W-1:0]   sd_ba,
  output logic [DATA_W/8-1:0] sd_dqm,
  output logic [DATA_W-1:0]   sd_dq_o,
  output logic                sd_dq_oe
);

  localparam int WR_CYC  = (T_RAS - T_RCD > T_WR) ? (T_RAS - T_RCD) : T_WR;
  localparam int RC_LEFT = T_RC - T_RCD - WR_CYC;
  localparam int RP_CYC  = (RC_LEFT > T_RP) ? RC_LEFT : T_RP;
  localparam int RDY_GAP = (RP_CYC > 1) ? (RP_CYC - 1) : 1;
  localparam int CNT_W   = $clog2(T_RCD + WR_CYC + RDY_GAP + 2);

  typedef enum logic [2:0] {
    S_IDLE, S_ACT, S_RCD, S_WR, S_REC, S_PRE, S_RP
  } state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] data_q;

  wire is_act = (state == S_ACT);
  wire is_wr  = (state == S_WR);
  wire is_pre = (state == S_PRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      data_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          bank_q <= req_bank;
          row_q  <= req_row;
          col_q  <= req_col;
          data_q <= req_data;
          state  <= S_ACT;
        end
        S_ACT: if (T_RCD <= 1) state <= S_WR;
               else begin state <= S_RCD; cnt <= CNT_W'(T_RCD - 2); end
        S_RCD: if (cnt == '0) state <= S_WR; else cnt <= cnt - 1'b1;
        S_WR:  if (WR_CYC <= 1) state <= S_PRE;
               else begin state <= S_REC; cnt <= CNT_W'(WR_CYC - 2); end
        S_REC: if (cnt == '0) state <= S_PRE; else cnt <= cnt - 1'b1;
        S_PRE: if (RDY_GAP <= 1) state <= S_IDLE;
               else begin state <= S_RP; cnt <= CNT_W'(RDY_GAP - 2); end
        S_RP:  if (cnt == '0) state <= S_IDLE; else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign sd_cke    = 1'b1;
  assign sd_cs_n   = 1'b0;
  assign sd_ras_n  = !(is_act || is_pre);
  assign sd_cas_n  = !is_wr;
  assign sd_we_n   = !(is_wr || is_pre);

  always_comb begin
    sd_addr = '0;
    if (is_act)     sd_addr = row_q;
    else if (is_wr) sd_addr = ROW_W'(col_q);
  end

  assign sd_ba    = (is_act || is_wr || is_pre) ? bank_q : '0;
  assign sd_dq_oe = is_wr;
  assign sd_dq_o  = is_wr ? data_q : '0;
  assign sd_dqm   = is_wr ? '0 : '1;

endmodule

// File: rtl/sdram_write_seq_chk.sv
module sdram_write_seq_chk #(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  parameter int DATA_W = 16,
  parameter int T_RCD  = 5,
  parameter int T_WR   = 4,
  parameter int T_RAS  = 11,
  parameter int T_RP   = 5,
  parameter int T_RC   = 15
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [BANK_W-1:0]   req_bank,
  input logic [ROW_W-1:0]    req_row,
  input logic [COL_W-1:0]    req_col,
  input logic [DATA_W-1:0]   req_data,
  input logic                sd_cke,
  input logic                sd_cs_n,
  input logic                sd_ras_n,
  input logic                sd_cas_n,
  input logic                sd_we_n,
  input logic [ROW_W-1:0]    sd_addr,
  input logic [BANK_W-1:0]   sd_ba,
  input logic [DATA_W/8-1:0] sd_dqm,
  input logic [DATA_W-1:0]   sd_dq_o,
  input logic                sd_dq_oe
);

  localparam int SAT   = T_RCD + T_WR + T_RAS + T_RP + T_RC;
  localparam int SAT_W = $clog2(SAT + 1);

  wire [3:0] cmd    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  wire       c_act  = (cmd == 4'b0011);
  wire       c_wr   = (cmd == 4'b0100);
  wire       c_pre  = (cmd == 4'b0010);
  wire       c_nop  = (cmd == 4'b0111);

  logic [SAT_W-1:0]  since_act, since_wr, since_pre;
  logic              row_open;
  logic [BANK_W-1:0] open_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= SAT_W'(SAT);
      since_wr  <= SAT_W'(SAT);
      since_pre <= SAT_W'(SAT);
      row_open  <= 1'b0;
      open_bank <= '0;
    end else begin
      since_act <= c_act ? SAT_W'(1) : (since_act < SAT_W'(SAT) ? since_act + 1'b1 : since_act);
      since_wr  <= c_wr  ? SAT_W'(1) : (since_wr  < SAT_W'(SAT) ? since_wr  + 1'b1 : since_wr);
      since_pre <= c_pre ? SAT_W'(1) : (since_pre < SAT_W'(SAT) ? since_pre + 1'b1 : since_pre);
      if (c_act) begin row_open <= 1'b1; open_bank <= sd_ba; end
      else if (c_pre) row_open <= 1'b0;
    end
  end

  // R2
  accept_then_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> c_act && sd_ba == $past(req_bank) && sd_addr == $past(req_row));

  // R3
  wr_after_rcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr |-> row_open && since_act >= SAT_W'(T_RCD) && !sd_addr[10] && sd_ba == open_bank);

  // R4
  dq_only_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> c_wr && sd_dqm == '0);

  // R5
  pre_after_ras_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_pre |-> since_act >= SAT_W'(T_RAS) && since_wr >= SAT_W'(T_WR));

  // R6
  pre_single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_pre |-> row_open && !sd_addr[10] && sd_ba == open_bank);

  // R7
  act_after_rp_rc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_act |-> !row_open && since_pre >= SAT_W'(T_RP) && since_act >= SAT_W'(T_RC));

  // R8
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !c_nop |-> !req_ready);

  // R9
  legal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_nop || c_act || c_wr || c_pre) && sd_cke);

endmodule

bind sdram_write_seq sdram_write_seq_chk #(
  .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .DATA_W(DATA_W),
  .T_RCD(T_RCD), .T_WR(T_WR), .T_RAS(T_RAS), .T_RP(T_RP), .T_RC(T_RC)
) u_chk (.*);

// File: tb/sdram_write_seq_test.sv
`timescale 1ns/1ps
module sdram_write_seq_test;
  localparam int T_RCD = 5, T_WR = 4, T_RAS = 11, T_RP = 5, T_RC = 15;
  localparam int NV = 5;
  // {stray, bank[2], row[13], col[8], data[16]}
  localparam logic [39:0] VEC [NV] = '{
    {1'b0, 2'd0, 13'h0000, 8'h00, 16'h0000},
    {1'b0, 2'd3, 13'h1FFF, 8'hFF, 16'hFFFF},
    {1'b1, 2'd1, 13'h0A5A, 8'h3C, 16'h1234},
    {1'b0, 2'd2, 13'h1555, 8'hA5, 16'hBEEF},
    {1'b1, 2'd3, 13'h0400, 8'h80, 16'h8001}
  };

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [1:0] req_bank = 0;
  logic [12:0] req_row = 0;
  logic [7:0] req_col = 0;
  logic [15:0] req_data = 0;
  logic req_ready, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [12:0] sd_addr;
  logic [1:0] sd_ba, sd_dqm;
  logic [15:0] sd_dq_o;

  sdram_write_seq #(.T_RCD(T_RCD), .T_WR(T_WR), .T_RAS(T_RAS), .T_RP(T_RP), .T_RC(T_RC)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_data(req_data),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_dqm(sd_dqm),
    .sd_dq_o(sd_dq_o), .sd_dq_oe(sd_dq_oe));

  always #2 clk = ~clk;

  int cyc = 0, n_chk = 0, n_bad = 0, next_act = -1;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", rq, cyc, act, exp);
    end
  endtask

  function automatic logic [4:0] cmd_now();
    return {sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  task automatic chk_idle(input string rq);
    chk(cmd_now() == 5'b10111, rq, 32'(cmd_now()), 32'h17);
    chk(req_ready == 1'b1, rq, 32'(req_ready), 32'h1);
    chk({sd_dq_oe, sd_dqm} == 3'b011, rq, 32'({sd_dq_oe, sd_dqm}), 32'h3);
  endtask

  task automatic run_req(input logic [39:0] v);
    logic stray = v[39];
    logic [1:0] bk = v[38:37];
    logic [12:0] rw = v[36:24];
    logic [7:0] cl = v[23:16];
    logic [15:0] dt = v[15:0];
    int a, w, p, n, rdy;
    chk(req_ready == 1'b1, "R7", 32'(req_ready), 32'h1);
    req_valid = 1; req_bank = bk; req_row = rw; req_col = cl; req_data = dt;
    @(negedge clk);
    req_valid = 0; req_bank = ~bk; req_row = ~rw; req_col = ~cl; req_data = ~dt;
    a = cyc;
    if (next_act >= 0) chk(a == next_act, "R7", 32'(a), 32'(next_act));
    w = a + T_RCD;
    p = a + ((T_RCD + T_WR > T_RAS) ? T_RCD + T_WR : T_RAS);
    n = (p + T_RP > a + T_RC) ? p + T_RP : a + T_RC;
    rdy = n - 1;
    for (int c = a; c <= rdy; c++) begin
      if (c > a) @(negedge clk);
      if (stray && c == a + 2) begin
        req_valid = 1; req_bank = ~bk; req_row = ~rw; req_col = ~cl; req_data = ~dt;
      end
      if (stray && c == a + 3) req_valid = 0;
      if (c == a) begin
        chk(cmd_now() == 5'b10011, "R2", 32'(cmd_now()), 32'h13);
        chk({sd_ba, sd_addr} == {bk, rw}, "R2", 32'({sd_ba, sd_addr}), 32'({bk, rw}));
      end else if (c == w) begin
        chk(cmd_now() == 5'b10100, "R3", 32'(cmd_now()), 32'h14);
        chk({sd_ba, sd_addr} == {bk, 5'b0, cl}, "R3", 32'({sd_ba, sd_addr}), 32'({bk, 5'b0, cl}));
        chk({sd_dq_oe, sd_dqm, sd_dq_o} == {3'b100, dt}, stray ? "R8" : "R4",
            32'({sd_dq_oe, sd_dqm, sd_dq_o}), 32'({3'b100, dt}));
      end else if (c == p) begin
        chk(cmd_now() == 5'b10010, "R5", 32'(cmd_now()), 32'h12);
        chk({sd_ba, sd_addr[10]} == {bk, 1'b0}, "R6", 32'({sd_ba, sd_addr[10]}), 32'({bk, 1'b0}));
      end else begin
        chk(cmd_now() == 5'b10111, stray ? "R8" : "R9", 32'(cmd_now()), 32'h17);
      end
      if (c != w) chk({sd_dq_oe, sd_dqm} == 3'b011, "R4", 32'({sd_dq_oe, sd_dqm}), 32'h3);
      chk(req_ready == (c == rdy), c == rdy ? "R7" : "R8", 32'(req_ready), 32'(c == rdy));
    end
    next_act = n;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk_idle("R1");
    req_valid = 1;
    @(negedge clk);
    chk_idle("R1");
    req_valid = 0;
    rst_n = 1;
    @(negedge clk);
    chk_idle("R1");
    for (int i = 0; i < NV; i++) run_req(VEC[i]);
    next_act = -1;
    repeat (3) begin
      @(negedge clk);
      chk_idle("R9");
    end
    run_req(VEC[1]);
    req_valid = 1; req_bank = 2'd2; req_row = 13'h0123; req_col = 8'h11; req_data = 16'h5A5A;
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk_idle("R1");
    rst_n = 1;
    @(negedge clk);
    chk_idle("R1");
    next_act = -1;
    run_req(VEC[3]);
    @(negedge clk);
    chk_idle("R9");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule